// File: doc/BRIEF.md
# Vector Prefix Detect and Sub-PC Sequencer

This block sits between instruction fetch and retire in a scalar core that also accepts a 64-bit vector-prefixed instruction form. It examines each fetched 32-bit word and decides whether that word is a vector prefix. For a prefix it extracts a 24-bit remap field and points the fetch unit at the 32-bit suffix that follows. It also computes the address of the next instruction.

While a prefixed instruction with a vector destination is retiring, the program counter stays where it is. Each retire instead advances an element index, which is held in a 32-bit vector state register. When the last element retires, the index returns to zero and the program counter moves past the whole 8-byte instruction. Operand decode uses the element index output as the offset to add to vector-marked register numbers.

The vector state register is loaded through a write port. That is how the vector length is set.

Top module: `vpx_seq_top`

## Requirements
- R1: `is_prefix` is 1 exactly when `fetch_word[31:26]` equals 1 and `fetch_word[24]` and `fetch_word[22]` are both 1 (LSB0 numbering). Otherwise it is 0.
- R2: For a word that is not a prefix, `next_pc` equals `pc + 4`. A retire strobe loads `next_pc` into `pc` on the next clock edge.
- R3: `suffix_pc` always equals `pc + 4`.
- R4: `remap` equals `{fetch_word[25], fetch_word[23], fetch_word[21:0]}`, with bit 25 as the MSB.
- R5: The state register `st_q` (LSB0) holds these fields:
  - maximum length in [31:25]
  - vector length VL in [24:18]
  - source step in [17:11]
  - destination step in [10:4]
  - sub-vector length in [3:2]
  - step mode in [1:0]

  When `st_load` is 1, the whole register takes `st_wdata` on the next edge, and that load wins over a retire. A retire changes only the source-step field.
- R6: A prefix retires with `dst_vec` = 1 while the source step is not the last index. In that case `next_pc` equals `pc`, the source step increments by one, and `pc` is unchanged after the edge.
- R7: A prefix retires with the source step at the last index, or with `dst_vec` = 0. In that case `next_pc` equals `pc + 8`, and after the edge the source step is 0 and `pc` has advanced by 8.
- R8: The last index is VL-1. When VL is 0, the last index is 0, so a vector instruction makes exactly one pass.
- R9: Without `retire` or `st_load`, `pc` and `st_q` keep their values across a clock edge.
- R10: A synchronous reset sets `pc` to `START_ADDR` and clears `st_q` to zero.
- R11: `elem_idx` always equals the source-step field. The source step is a 7-bit counter that wraps from 127 to 0.
- R12: A retire of a word that is not a prefix leaves the source step unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_word | input | 32 | Word fetched at `pc` |
| retire | input | 1 | The instruction at `pc` retires this cycle |
| dst_vec | input | 1 | The destination of the retiring instruction is a vector |
| st_load | input | 1 | Load the vector state register |
| st_wdata | input | 32 | Value to load into the vector state register |
| pc | output | AW | Current instruction address |
| next_pc | output | AW | Address that follows the current instruction |
| suffix_pc | output | AW | Address of the suffix word of a prefixed instruction |
| is_prefix | output | 1 | The fetched word is a vector prefix |
| remap | output | 24 | Remap field gathered from the prefix |
| elem_idx | output | 7 | Current element index (source step) |
| st_q | output | 32 | Vector state register |

## Verification
The bench sweeps all 64 major-opcode values against all four combinations of the two identifier bits. A detector that tested the wrong bit, or that ignored one of the identifier bits, would flag ordinary instructions as prefixes and skip 4 bytes of code.

The bench then runs VL from 0 to 9 with vector and scalar destinations and counts the retires before the address moves. An off-by-one in the last-index compare would give one element too many or too few. Mishandling VL = 0 would spin for 128 passes or lock the core.

Further checks cover:
- a counter preloaded to 127, which must wrap to 0 while the address holds;
- the remaining state fields, which must survive a loop unchanged;
- idle cycles, which must change nothing.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
    localparam int STEP_W    = 7;
    localparam int RM_W      = 24;
    localparam int WORD_W    = 32;
    localparam logic [5:0] PFX_MAJOR = 6'd1;
    localparam int INSN_BYTES = 4;

    typedef struct packed {
        logic [STEP_W-1:0] maxvl;
        logic [STEP_W-1:0] vl;
        logic [STEP_W-1:0] srcstep;
        logic [STEP_W-1:0] dststep;
        logic [1:0]        subvl;
        logic [1:0]        svmode;
    } vstate_t;
endpackage

// File: rtl/vpx_prefix_decode.sv
module vpx_prefix_decode
    import vpx_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              is_pfx_o,
    output logic [RM_W-1:0]   remap_o
);
    localparam int LOW_W = RM_W - 2;

    logic [LOW_W-1:0] low_bits;

    // Lower remap bits map straight across from the word's low bits.
    for (genvar g = 0; g < LOW_W; g++) begin : g_rm
        assign low_bits[g] = word_i[g];
    end

    always_comb begin
        is_pfx_o = (word_i[WORD_W-1 -: 6] == PFX_MAJOR) && word_i[24] && word_i[22];
        remap_o  = {word_i[25], word_i[23], low_bits};
    end
endmodule

// File: rtl/vpx_step_ctrl.sv
module vpx_step_ctrl
    import vpx_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic [STEP_W-1:0] vl_i,
    input  logic              is_pfx_i,
    input  logic              dst_vec_i,
    output logic              hold_o,
    output logic [STEP_W-1:0] step_nxt_o
);
    logic [STEP_W-1:0] last_idx;

    always_comb begin
        last_idx = (vl_i == '0) ? '0 : vl_i - STEP_W'(1);
        hold_o   = is_pfx_i && dst_vec_i && (step_i != last_idx);
        if (hold_o)
            step_nxt_o = step_i + STEP_W'(1);
        else if (is_pfx_i)
            step_nxt_o = '0;
        else
            step_nxt_o = step_i;
    end
endmodule

// File: rtl/vpx_seq_top.sv
module vpx_seq_top
    import vpx_pkg::*;
#(
    parameter int AW = 64,
    parameter logic [AW-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       fetch_word,
    input  logic              retire,
    input  logic              dst_vec,
    input  logic              st_load,
    input  logic [31:0]       st_wdata,
    output logic [AW-1:0]     pc,
    output logic [AW-1:0]     next_pc,
    output logic [AW-1:0]     suffix_pc,
    output logic              is_prefix,
    output logic [23:0]       remap,
    output logic [6:0]        elem_idx,
    output logic [31:0]       st_q
);
    localparam logic [AW-1:0] STEP4 = AW'(INSN_BYTES);
    localparam logic [AW-1:0] STEP8 = AW'(2 * INSN_BYTES);

    typedef struct packed {
        logic [AW-1:0] pc;
        vstate_t       vs;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic              hold;
    logic [STEP_W-1:0] step_nxt;

    vpx_prefix_decode u_dec (
        .word_i   (fetch_word),
        .is_pfx_o (is_prefix),
        .remap_o  (remap)
    );

    vpx_step_ctrl u_step (
        .step_i     (seq_q.vs.srcstep),
        .vl_i       (seq_q.vs.vl),
        .is_pfx_i   (is_prefix),
        .dst_vec_i  (dst_vec),
        .hold_o     (hold),
        .step_nxt_o (step_nxt)
    );

    always_comb begin
        suffix_pc = seq_q.pc + STEP4;
        if (hold)
            next_pc = seq_q.pc;
        else if (is_prefix)
            next_pc = seq_q.pc + STEP8;
        else
            next_pc = seq_q.pc + STEP4;

        seq_d = seq_q;
        if (st_load) begin
            seq_d.vs = vstate_t'(st_wdata);
        end else if (retire) begin
            seq_d.pc         = next_pc;
            seq_d.vs.srcstep = step_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.pc <= START_ADDR;
            seq_q.vs <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pc       = seq_q.pc;
    assign elem_idx = seq_q.vs.srcstep;
    assign st_q     = seq_q.vs;
endmodule

// File: rtl/vpx_seq_chk.sv
module vpx_seq_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          retire,
    input logic          dst_vec,
    input logic          st_load,
    input logic          is_prefix,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] suffix_pc,
    input logic [6:0]    elem_idx,
    input logic [31:0]   st_q
);
    logic [6:0] c_vl;
    logic [6:0] c_last;
    logic       c_loop;

    assign c_vl   = st_q[24:18];
    assign c_last = (c_vl == 7'd0) ? 7'd0 : c_vl - 7'd1;
    assign c_loop = retire && !st_load && is_prefix && dst_vec && (elem_idx != c_last);

    AST_PC_HOLD_LOOP: assert property (@(posedge clk) disable iff (rst)
        c_loop |=> $stable(pc)); // R6

    AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
        c_loop |=> elem_idx == $past(elem_idx) + 7'd1); // R6

    AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (retire && !st_load && is_prefix && !c_loop) |=> (elem_idx == 7'd0)); // R7

    AST_PFX_ADV8: assert property (@(posedge clk) disable iff (rst)
        (retire && !st_load && is_prefix && !c_loop) |=> pc == $past(pc) + AW'(8)); // R7

    AST_SCALAR_ADV4: assert property (@(posedge clk) disable iff (rst)
        (retire && !st_load && !is_prefix) |=> pc == $past(pc) + AW'(4)); // R2

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!retire && !st_load) |=> ($stable(pc) && $stable(st_q))); // R9

    AST_ELEM_FIELD: assert property (@(posedge clk) disable iff (rst)
        elem_idx == st_q[17:11]); // R11

    always_comb begin
        if (!rst) AST_SUFFIX_ADDR: assert (suffix_pc == pc + AW'(4)); // R3
    end
endmodule

bind vpx_seq_top vpx_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .retire    (retire),
    .dst_vec   (dst_vec),
    .st_load   (st_load),
    .is_prefix (is_prefix),
    .pc        (pc),
    .suffix_pc (suffix_pc),
    .elem_idx  (elem_idx),
    .st_q      (st_q)
);

// File: tb/vpx_seq_top_test.sv
module vpx_seq_top_test;
    localparam int AW = 32;
    localparam logic [AW-1:0] START = 32'h0000_1000;
    localparam logic [31:0] PFX_WORD = {6'd1, 1'b0, 1'b1, 1'b0, 1'b1, 22'h0ABCD};
    localparam logic [31:0] PLAIN_WORD = {6'd14, 26'h0000123};

    logic          clk = 1'b0;
    logic          rst;
    logic [31:0]   fetch_word;
    logic          retire, dst_vec, st_load;
    logic [31:0]   st_wdata;
    logic [AW-1:0] pc, next_pc, suffix_pc;
    logic          is_prefix;
    logic [23:0]   remap;
    logic [6:0]    elem_idx;
    logic [31:0]   st_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vpx_seq_top #(.AW(AW), .START_ADDR(START)) uut (
        .clk(clk), .rst(rst), .fetch_word(fetch_word), .retire(retire),
        .dst_vec(dst_vec), .st_load(st_load), .st_wdata(st_wdata),
        .pc(pc), .next_pc(next_pc), .suffix_pc(suffix_pc),
        .is_prefix(is_prefix), .remap(remap), .elem_idx(elem_idx), .st_q(st_q)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_state(input logic [31:0] v);
        st_load  = 1'b1;
        st_wdata = v;
        tick();
        st_load = 1'b0;
        #1;
        check(st_q == v, "R5 load", st_q, v);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fetch_word = PLAIN_WORD; retire = 1'b0; dst_vec = 1'b0;
        st_load = 1'b0; st_wdata = '0;
        tick(); tick();
        rst = 1'b0;
        #1;
        // R10 reset state
        check(pc == START, "R10 pc", pc, START);
        check(st_q == 32'h0, "R10 state", st_q, 0);

        // R1, R3, R4: sweep of major opcode and identifier bits
        for (int m = 0; m < 64; m++) begin
            for (int b = 0; b < 4; b++) begin
                logic [31:0] w;
                logic        ep;
                logic [AW-1:0] enx;
                w = {m[5:0], m[0], b[1], ~m[1], b[0], 22'(m * 4099 + b * 77)};
                fetch_word = w;
                #1;
                ep  = (m == 1) && (b == 3);
                enx = pc + (ep ? 32'd8 : 32'd4);
                check(is_prefix == ep, "R1", is_prefix, ep);
                check(remap == {w[25], w[23], w[21:0]}, "R4", remap, {w[25], w[23], w[21:0]});
                check(suffix_pc == pc + 32'd4, "R3", suffix_pc, pc + 32'd4);
                check(next_pc == enx, "R2/R7 next", next_pc, enx);
                @(negedge clk);
            end
        end

        // R2 and R12: plain retire advances by 4, step untouched
        load_state({7'd9, 7'd6, 7'd3, 7'd0, 2'd0, 2'd0});
        begin
            logic [AW-1:0] p0;
            p0 = pc;
            fetch_word = PLAIN_WORD; dst_vec = 1'b1; retire = 1'b1;
            tick();
            retire = 1'b0;
            #1;
            check(pc == p0 + 32'd4, "R2 advance", pc, p0 + 32'd4);
            check(elem_idx == 7'd3, "R12 step kept", elem_idx, 3);
        end

        // R6, R7, R8, R5: element loop for several vector lengths
        for (int vl = 0; vl < 10; vl++) begin
            for (int v = 0; v < 2; v++) begin
                logic [31:0] sv;
                logic [AW-1:0] p0;
                int iters;
                sv = {7'd20, 7'(vl), 7'd0, 7'd5, 2'd1, 2'd2};
                load_state(sv);
                p0 = pc;
                iters = (v == 1) ? ((vl == 0) ? 1 : vl) : 1;
                fetch_word = PFX_WORD; dst_vec = v[0];
                for (int k = 0; k < iters; k++) begin
                    logic [AW-1:0] enx;
                    retire = 1'b1;
                    #1;
                    enx = (k < iters - 1) ? p0 : p0 + 32'd8;
                    check(elem_idx == 7'(k), "R6 elem_idx", elem_idx, k);
                    check(next_pc == enx, "R6/R8 next_pc", next_pc, enx);
                    tick();
                    retire = 1'b0;
                    #1;
                    if (k < iters - 1)
                        check(pc == p0, "R6 pc hold", pc, p0);
                end
                check(pc == p0 + 32'd8, "R7 pc +8", pc, p0 + 32'd8);
                check(elem_idx == 7'd0, "R7 step cleared", elem_idx, 0);
                check({st_q[31:18], st_q[10:0]} == {sv[31:18], sv[10:0]},
                      "R5 fields kept", st_q, sv);
            end
        end

        // R11: wrap from 127 to 0 while looping
        load_state({7'd20, 7'd10, 7'd127, 7'd0, 2'd0, 2'd0});
        begin
            logic [AW-1:0] p0;
            p0 = pc;
            fetch_word = PFX_WORD; dst_vec = 1'b1; retire = 1'b1;
            #1;
            check(next_pc == p0, "R11 hold at 127", next_pc, p0);
            tick();
            retire = 1'b0;
            #1;
            check(elem_idx == 7'd0, "R11 wrap", elem_idx, 0);
            check(pc == p0, "R11 pc held", pc, p0);

            // R9: idle edges change nothing
            tick(); tick();
            #1;
            check(pc == p0, "R9 pc idle", pc, p0);
            check(st_q == {7'd20, 7'd10, 7'd0, 7'd0, 2'd0, 2'd0}, "R9 state idle",
                  st_q, {7'd20, 7'd10, 7'd0, 7'd0, 2'd0, 2'd0});

            // R5: load wins over a simultaneous retire
            st_load = 1'b1; st_wdata = {7'd1, 7'd4, 7'd2, 7'd0, 2'd0, 2'd0}; retire = 1'b1;
            tick();
            st_load = 1'b0; retire = 1'b0;
            #1;
            check(pc == p0, "R5 load priority pc", pc, p0);
            check(elem_idx == 7'd2, "R5 load priority step", elem_idx, 2);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule